// File: doc/BRIEF.md
# Pointer-Mode Load Address Generator

This block sits in the load path of a small 8-bit RISC core whose instruction words are 16 bits wide. It recognises the load encodings that take their memory address from one of two 16-bit pointer pairs in the register file. For each one it produces the data-memory byte address, the destination register index and, where the mode calls for it, the value to write back into the pointer pair. The register file supplies both pointer values in the same cycle as the instruction word. The caller writes the returned pointer value back, and a separate memory stage performs the access.

Four access styles are covered. Plain indirect uses the pointer as it stands. Indirect with an unsigned 6-bit displacement adds a constant and leaves the pointer alone. Pre-decrement lowers the pointer first and then uses the lowered value as the address. Post-increment uses the unchanged pointer as the address and then raises it. Any word outside these encodings raises an illegal flag and never requests a pointer update. All results are registered and appear one clock after the input strobe.

Top module: `ptr_agen`

## Requirements
- R1: While reset is held low on a clock edge, out_valid, ptr_wr_en and illegal are all 0 after that edge.
- R2: A word with bits[15:14]=10, bit12=0 and bit9=0 is a displacement load. The displacement is {bit13, bits[11:10], bits[2:0]}, unsigned. The address is the selected pointer plus the displacement, and ptr_wr_en is 0.
- R3: A displacement load whose six displacement bits are all zero (plain indirect) gives an address equal to the selected pointer.
- R4: In a displacement load, bit3 = 1 selects the Y pair and bit3 = 0 selects the Z pair.
- R5: A word with bits[15:9]=1001000 and low nibble 1010 (Y) or 0010 (Z) is a pre-decrement load. The address and ptr_new both equal the pointer minus one, and ptr_wr_en is 1.
- R6: A word with bits[15:9]=1001000 and low nibble 1001 (Y) or 0001 (Z) is a post-increment load. The address equals the unchanged pointer, ptr_new equals the pointer plus one, and ptr_wr_en is 1.
- R7: All pointer arithmetic wraps modulo 2^16. Pre-decrement of 0x0000 gives 0xFFFF, post-increment of 0xFFFF gives 0x0000, and a displacement sum past 0xFFFF wraps.
- R8: A valid word that matches none of the encodings above sets illegal to 1, ptr_wr_en to 0 and mem_addr to 0.
- R9: For every recognised load, dst_reg equals bits[8:4] of the word.
- R10: Outputs are registered. out_valid follows in_valid one clock later, and a cycle without in_valid yields out_valid, ptr_wr_en and illegal all 0.
- R11: On a pointer update, ptr_wr_sel is 1 for the Y pair and 0 for the Z pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| ptr_y | input | 16 | Current Y pointer (r29:r28) |
| ptr_z | input | 16 | Current Z pointer (r31:r30) |
| out_valid | output | 1 | Registered results are valid |
| mem_addr | output | 16 | Data-memory byte address |
| dst_reg | output | 5 | Destination register index |
| ptr_wr_en | output | 1 | Pointer pair must be written back |
| ptr_wr_sel | output | 1 | Pair to write back: 1 Y, 0 Z |
| ptr_new | output | 16 | Value to write into the pointer pair |
| illegal | output | 1 | Word is not a supported pointer load |

## Verification
The address computation and the pointer side effect occur in the same cycle for the auto-modifying modes. In pre-decrement the address must equal the new pointer. In post-increment the address must sit one below it. The bench provokes this by sweeping all 65536 instruction words with pointer values that change each cycle. It adds targeted runs at 0x0000 and 0xFFFF, where the decrement and increment wrap. Each output is compared against an arithmetic model of the encodings. An assertion also ties the address and the write-back value together whenever an update is requested.

// File: rtl/agen_pkg.sv
// Shared types for the pointer-mode load address generator.
// Assumes 16-bit instruction words; field positions are fixed by the encoding.
package agen_pkg;

    localparam int INSTR_W = 16;
    localparam int DISP_W  = 6;
    localparam int REG_W   = 5;

    typedef enum logic [1:0] {
        AM_ILL  = 2'd0,
        AM_DISP = 2'd1,
        AM_PRE  = 2'd2,
        AM_POST = 2'd3
    } am_mode_e;

    typedef struct packed {
        am_mode_e            mode;
        logic                use_y;
        logic [DISP_W-1:0]   disp;
        logic [REG_W-1:0]    dst;
    } agen_dec_t;

endpackage

// File: rtl/agen_decode.sv
// Classifies a 16-bit word as one of the pointer load forms and extracts fields.
// Purely combinational; assumes the caller qualifies the result with a valid strobe.
module agen_decode
    import agen_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output agen_dec_t          dec
);

    localparam logic [6:0] AUTO_TOP = 7'b1001000;

    // Match the displacement form first, then the auto-modify group.
    always_comb begin
        dec.mode  = AM_ILL;
        dec.use_y = 1'b0;
        dec.disp  = '0;
        dec.dst   = word[8:4];
        if (word[15:14] == 2'b10 && !word[12] && !word[9]) begin
            dec.mode  = AM_DISP;
            dec.use_y = word[3];
            dec.disp  = {word[13], word[11:10], word[2:0]};
        end else if (word[15:9] == AUTO_TOP) begin
            case (word[3:0])
                4'b1010: begin dec.mode = AM_PRE;  dec.use_y = 1'b1; end
                4'b1001: begin dec.mode = AM_POST; dec.use_y = 1'b1; end
                4'b0010: begin dec.mode = AM_PRE;  dec.use_y = 1'b0; end
                4'b0001: begin dec.mode = AM_POST; dec.use_y = 1'b0; end
                default: dec.mode = AM_ILL;
            endcase
        end
    end

endmodule

// File: rtl/agen_calc.sv
// Computes address and pointer write-back value from a decoded word.
// Combinational; arithmetic wraps modulo 2^AW. Assumes AW >= DISP_W.
module agen_calc
    import agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  agen_dec_t        dec,
    input  logic [AW-1:0]    ptr_y,
    input  logic [AW-1:0]    ptr_z,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    new_ptr,
    output logic             wr_en,
    output logic             bad
);

    logic [AW-1:0] base;
    logic [AW-1:0] base_dn;
    logic [AW-1:0] base_up;
    logic [AW-1:0] base_off;

    // Select the pointer pair and form the three candidate values.
    always_comb begin
        base     = dec.use_y ? ptr_y : ptr_z;
        base_dn  = base - AW'(1);
        base_up  = base + AW'(1);
        base_off = base + AW'(dec.disp);
    end

    // Pick the address and side effect for the decoded mode.
    always_comb begin
        addr    = '0;
        new_ptr = '0;
        wr_en   = 1'b0;
        bad     = 1'b0;
        unique case (dec.mode)
            AM_DISP: addr = base_off;
            AM_PRE:  begin addr = base_dn; new_ptr = base_dn; wr_en = 1'b1; end
            AM_POST: begin addr = base;    new_ptr = base_up; wr_en = 1'b1; end
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/ptr_agen.sv
// Pointer-mode load address generator: decode, compute, then register all results.
// Assumes pointer values are stable with instr in the strobe cycle; results appear one clock later.
module ptr_agen
    import agen_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [AW-1:0]      ptr_y,
    input  logic [AW-1:0]      ptr_z,
    output logic               out_valid,
    output logic [AW-1:0]      mem_addr,
    output logic [REG_W-1:0]   dst_reg,
    output logic               ptr_wr_en,
    output logic               ptr_wr_sel,
    output logic [AW-1:0]      ptr_new,
    output logic               illegal
);

    agen_dec_t     dec;
    logic [AW-1:0] c_addr;
    logic [AW-1:0] c_new;
    logic          c_wr;
    logic          c_bad;

    agen_decode u_dec (
        .word (instr),
        .dec  (dec)
    );

    agen_calc #(.AW(AW)) u_calc (
        .dec     (dec),
        .ptr_y   (ptr_y),
        .ptr_z   (ptr_z),
        .addr    (c_addr),
        .new_ptr (c_new),
        .wr_en   (c_wr),
        .bad     (c_bad)
    );

    // Output register stage; strobe gates every flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            mem_addr   <= '0;
            dst_reg    <= '0;
            ptr_wr_en  <= 1'b0;
            ptr_wr_sel <= 1'b0;
            ptr_new    <= '0;
            illegal    <= 1'b0;
        end else begin
            out_valid  <= in_valid;
            mem_addr   <= c_addr;
            dst_reg    <= dec.dst;
            ptr_wr_en  <= in_valid && c_wr;
            ptr_wr_sel <= dec.use_y;
            ptr_new    <= c_new;
            illegal    <= in_valid && c_bad;
        end
    end

    AST_STROBE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_WR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_en |-> out_valid); // R10
    AST_ILLEGAL_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!ptr_wr_en && mem_addr == '0)); // R8
    AST_DISP_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec.mode == AM_DISP) |=> !ptr_wr_en); // R2
    AST_UPDATE_PAIRING: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr_en |-> (mem_addr == ptr_new || AW'(mem_addr + AW'(1)) == ptr_new)); // R6

endmodule

// File: tb/tb_ptr_agen.sv
module tb_ptr_agen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] ptr_y = '0;
    logic [15:0] ptr_z = '0;
    logic        out_valid;
    logic [15:0] mem_addr;
    logic [4:0]  dst_reg;
    logic        ptr_wr_en;
    logic        ptr_wr_sel;
    logic [15:0] ptr_new;
    logic        illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptr_agen dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .ptr_y(ptr_y), .ptr_z(ptr_z), .out_valid(out_valid), .mem_addr(mem_addr),
        .dst_reg(dst_reg), .ptr_wr_en(ptr_wr_en), .ptr_wr_sel(ptr_wr_sel),
        .ptr_new(ptr_new), .illegal(illegal)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h instr=%h", tag, what, act, exp, instr);
        end
    endtask

    // Arithmetic model of the encodings, built from the requirements.
    task automatic model(input logic [15:0] w, input logic [15:0] y, input logic [15:0] z,
                         output bit ill, output bit wr, output bit sel,
                         output logic [15:0] a, output logic [15:0] np, output string tag);
        logic [15:0] p;
        int q;
        ill = 1'b0; wr = 1'b0; sel = 1'b0; a = 16'h0; np = 16'h0; tag = "R8";
        if (w[15:14] == 2'b10 && w[12] == 1'b0 && w[9] == 1'b0) begin
            q = int'(w[13]) * 32 + int'(w[11:10]) * 8 + int'(w[2:0]);
            sel = w[3];
            p = sel ? y : z;
            a = 16'((int'(p) + q) % 65536);
            tag = (q == 0) ? "R3" : "R2";
        end else if (w[15:9] == 7'b1001000 && (w[3:0] == 4'd10 || w[3:0] == 4'd2)) begin
            sel = w[3];
            p = sel ? y : z;
            a = 16'((int'(p) + 65535) % 65536);
            np = a; wr = 1'b1; tag = "R5";
        end else if (w[15:9] == 7'b1001000 && (w[3:0] == 4'd9 || w[3:0] == 4'd1)) begin
            sel = w[3];
            p = sel ? y : z;
            a = p;
            np = 16'((int'(p) + 1) % 65536); wr = 1'b1; tag = "R6";
        end else begin
            ill = 1'b1;
        end
    endtask

    // Drive one word, then sample a half cycle after the capturing edge.
    task automatic step(input logic [15:0] w, input logic [15:0] y, input logic [15:0] z, input string override);
        bit ill, wr, sel;
        logic [15:0] a, np;
        string tag;
        @(negedge clk);
        in_valid = 1'b1; instr = w; ptr_y = y; ptr_z = z;
        model(w, y, z, ill, wr, sel, a, np, tag);
        if (override != "") tag = override;
        @(posedge clk);
        @(negedge clk);
        chk("R10", "out_valid", 16'(out_valid), 16'd1);
        chk(tag, "illegal", 16'(illegal), 16'(ill));
        chk(tag, "ptr_wr_en", 16'(ptr_wr_en), 16'(wr));
        chk(tag, "mem_addr", mem_addr, a);
        if (!ill) begin
            chk("R9", "dst_reg", 16'(dst_reg), 16'(w[8:4]));
            chk(w[15] && !w[12] && !w[14] ? "R4" : "R11", "ptr_wr_sel", 16'(ptr_wr_sel), 16'(sel));
        end
        if (wr) chk(tag, "ptr_new", ptr_new, np);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "out_valid", 16'(out_valid), 16'd0);
        chk("R1", "ptr_wr_en", 16'(ptr_wr_en), 16'd0);
        chk("R1", "illegal", 16'(illegal), 16'd0);
        rst_n = 1'b1;

        // Strobe low with a legal auto-modify word: nothing reported (R10).
        in_valid = 1'b0; instr = 16'h900A; ptr_y = 16'h0100;
        @(posedge clk); @(negedge clk);
        chk("R10", "out_valid idle", 16'(out_valid), 16'd0);
        chk("R10", "ptr_wr_en idle", 16'(ptr_wr_en), 16'd0);
        chk("R10", "illegal idle", 16'(illegal), 16'd0);

        // Wrap corners for both pairs (R7).
        step(16'h900A, 16'h0000, 16'h5555, "R7");
        step(16'h9002, 16'h5555, 16'h0000, "R7");
        step(16'h9009, 16'hFFFF, 16'h5555, "R7");
        step(16'h9001, 16'h5555, 16'hFFFF, "R7");
        step(16'hAC0F, 16'hFFF0, 16'h0000, "R7");
        step(16'hAC07, 16'h0000, 16'hFFFA, "R7");

        // Full sweep of every word with changing pointer values.
        for (int w = 0; w < 65536; w++) begin
            step(16'(w), 16'(w * 7919), 16'(~(w * 31)), "");
        end

        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule